// File: doc/BRIEF.md
# Shared Timer Tick Prescaler with Synchronous Hold

This block produces the count-enable ticks for two timer/counters from one system clock. A free-running 10-bit counter provides single-cycle enables at four division ratios. Each timer has a 3-bit source select that picks one of these: no ticks, a tick every cycle, a prescaled tap, or a resynchronized edge of that timer's own external pin. The two timers share the single prescaler.

An 8-bit control register holds a prescaler-clear bit and a hold-mode bit. With hold mode off, writing the clear bit restarts the prescaler for one cycle. With hold mode on, the clear bit stays as written, so the prescaled and undivided ticks of both timers are frozen. Writing hold mode back to 0 drops the clear, and both timers then resume from the same prescaler phase. The register also stores a capture-select bit, which is only passed on to a neighbouring block.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset the register reads 0x00, `cap_sel_o` is 0 and both tick outputs are 0.
- R2: A write stores data bit 7 (hold mode), bit 6 (capture select, also driven on `cap_sel_o`) and bit 0 (prescaler clear) at those read-back positions. Read-back bits 5..1 are always 0.
- R3: With hold mode 0, a clear bit written as 1 reads back as 1 for exactly one cycle and then returns to 0 on its own.
- R4: With hold mode 1, the clear bit keeps its written value. While the clear bit is 1, ticks of select codes 1..5 are 0 on both timers.
- R5: A write with bit 7 = 0 and bit 0 = 0 releases a held clear in the next cycle. Both timers then count from the same prescaler phase: counting the first released cycle as 0, a divide-by-N tick is high in every cycle whose index is N-1 modulo N.
- R6: Select code 0 gives no ticks. Code 1 gives a tick in every cycle while the clear bit is 0.
- R7: Select codes 2, 3, 4 and 5 give single-cycle ticks at divide-by 8, 64, 256 and 1024 of the free-running prescaler count.
- R8: Select code 7 gives a one-cycle tick for each rising edge of the timer's pin. If the pin changes just before rising clock edge k, the tick is high during the cycle that follows edge k+2.
- R9: Select code 6 does the same as R8 for falling pin edges.
- R10: External-edge ticks are never divided and are not blocked by the prescaler clear.
- R11: Each timer uses its own select field (timer t at `sel_i[3t+2:3t]`) and its own pin `ext_i[t]`, with no effect on the other timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read-back |
| cap_sel_o | output | 1 | Stored capture-select bit |
| sel_i | input | 6 | Per-timer 3-bit tick source selects |
| ext_i | input | 2 | Per-timer external clock pins |
| tick_o | output | 2 | Per-timer count-enable ticks |

## Verification
The hardest behaviour to reach from the ports is the release after a long hold. The divide-by-1024 phase of both timers after release can only be seen if the prescaler is frozen, the selects are changed while it is frozen, and then more than a thousand cycles are run. The stimulus does this as a directed sequence: it holds the prescaler while both selects sit on tap codes, releases it, and runs past a full 1024 period while comparing every cycle against a bench model. A second directed pass toggles the external pins while the prescaler is held, to show that edge ticks get through. A seeded random phase then mixes register writes, select changes and pin toggles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TAPS = 4;
  localparam int SEL_W    = 3;
  localparam int REG_W    = 8;
  localparam int HOLD_BIT = 7;
  localparam int CAP_BIT  = 6;
  localparam int CLR_BIT  = 0;
  localparam int unsigned TAP_LOG2 [NUM_TAPS] = '{3, 6, 8, 10};

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF      = 3'd0,
    SRC_CLK      = 3'd1,
    SRC_D8       = 3'd2,
    SRC_D64      = 3'd3,
    SRC_D256     = 3'd4,
    SRC_D1024    = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } tick_src_e;

  typedef struct packed {
    logic hold;
    logic cap_sel;
    logic clr;
  } ctl_t;
endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (we_i) begin
      ctl_q.hold    <= wdata_i[HOLD_BIT];
      ctl_q.cap_sel <= wdata_i[CAP_BIT];
      ctl_q.clr     <= wdata_i[CLR_BIT];
    end else if (!ctl_q.hold) begin
      // clear self-terminates unless held
      ctl_q.clr <= 1'b0;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int unsigned L = TAP_LOG2[t];
    assign tap_o[t] = !clr_i && (&cnt_q[L-1:0]);
  end
endmodule

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      last_q <= sync_q[SYNC_STAGES-1];
      rise_q <= sync_q[SYNC_STAGES-1] & ~last_q;
      fall_q <= ~sync_q[SYNC_STAGES-1] & last_q;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux
  import tmr_pkg::*;
(
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                run_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                tick_o
);
  always_comb begin
    unique case (tick_src_e'(sel_i))
      SRC_OFF:      tick_o = 1'b0;
      SRC_CLK:      tick_o = run_i;
      SRC_D8:       tick_o = tap_i[0];
      SRC_D64:      tick_o = tap_i[1];
      SRC_D256:     tick_o = tap_i[2];
      SRC_D1024:    tick_o = tap_i[3];
      SRC_EXT_FALL: tick_o = fall_i;
      SRC_EXT_RISE: tick_o = rise_i;
      default:      tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int NUM_TMR     = 2,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ctl_we_i,
  input  logic [REG_W-1:0]         ctl_wdata_i,
  output logic [REG_W-1:0]         ctl_rdata_o,
  output logic                     cap_sel_o,
  input  logic [NUM_TMR*SEL_W-1:0] sel_i,
  input  logic [NUM_TMR-1:0]       ext_i,
  output logic [NUM_TMR-1:0]       tick_o
);
  ctl_t                ctl;
  logic [NUM_TAPS-1:0] tap;

  tmr_ctl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl)
  );

  tmr_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctl.clr),
    .tap_o  (tap)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic rise, fall;

    tmr_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_i[t]),
      .rise_o (rise),
      .fall_o (fall)
    );

    tmr_tick_mux u_mux (
      .sel_i  (sel_i[t*SEL_W +: SEL_W]),
      .run_i  (!ctl.clr),
      .tap_i  (tap),
      .rise_i (rise),
      .fall_i (fall),
      .tick_o (tick_o[t])
    );
  end

  always_comb begin
    ctl_rdata_o           = '0;
    ctl_rdata_o[HOLD_BIT] = ctl.hold;
    ctl_rdata_o[CAP_BIT]  = ctl.cap_sel;
    ctl_rdata_o[CLR_BIT]  = ctl.clr;
  end

  assign cap_sel_o = ctl.cap_sel;
endmodule

// File: rtl/tmr_tick_chk.sv
module tmr_tick_chk
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     ctl_we_i,
  input logic [REG_W-1:0]         ctl_rdata_o,
  input logic                     cap_sel_o,
  input logic [NUM_TMR*SEL_W-1:0] sel_i,
  input logic [NUM_TMR-1:0]       tick_o
);
  // R2: unused read-back bits stay zero, capture output follows bit 6
  a_r2_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[5:1] == '0 && cap_sel_o == ctl_rdata_o[CAP_BIT]);

  // R3: clear self-terminates without hold
  a_r3_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_rdata_o[HOLD_BIT] && ctl_rdata_o[CLR_BIT] && !ctl_we_i) |=> !ctl_rdata_o[CLR_BIT]);

  // R4: clear is kept under hold
  a_r4_clr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[HOLD_BIT] && ctl_rdata_o[CLR_BIT] && !ctl_we_i) |=> ctl_rdata_o[CLR_BIT]);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    logic [SEL_W-1:0] s;
    assign s = sel_i[t*SEL_W +: SEL_W];

    // R4: prescaled and undivided ticks frozen while clear is set
    a_r4_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_rdata_o[CLR_BIT] && s >= 3'd1 && s <= 3'd5) |-> !tick_o[t]);

    // R6: stopped source never ticks
    a_r6_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s == 3'd0) |-> !tick_o[t]);

    // R6: undivided source ticks every running cycle
    a_r6_every: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s == 3'd1 && !ctl_rdata_o[CLR_BIT]) |-> tick_o[t]);

    // R8: an external edge tick lasts one cycle
    a_r8_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s[2:1] == 2'b11 && tick_o[t] && $stable(sel_i)) |=>
        ($changed(sel_i) || !tick_o[t]));
  end
endmodule

bind tmr_tick_gen tmr_tick_chk #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .ctl_rdata_o (ctl_rdata_o),
  .cap_sel_o   (cap_sel_o),
  .sel_i       (sel_i),
  .tick_o      (tick_o)
);

// File: tb/sim_tmr_tick_gen.sv
`timescale 1ns/1ps
module sim_tmr_tick_gen;
  localparam int NT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    wd = '0;
  logic [7:0]    rd;
  logic          cap;
  logic [NT*3-1:0] sel = '0;
  logic [NT-1:0] ext = '0;
  logic [NT-1:0] tick;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string phase = "R1";

  // bench model state
  bit       m_hold, m_cap, m_clr;
  int       m_cnt;
  bit [3:0] m_ph [NT];

  always #2 clk = ~clk;

  tmr_tick_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wd),
    .ctl_rdata_o(rd), .cap_sel_o(cap), .sel_i(sel), .ext_i(ext), .tick_o(tick)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold <= 0; m_cap <= 0; m_clr <= 0; m_cnt <= 0;
      for (int t = 0; t < NT; t++) m_ph[t] <= '0;
    end else begin
      if (we) begin
        m_hold <= wd[7]; m_cap <= wd[6]; m_clr <= wd[0];
      end else if (!m_hold) m_clr <= 0;
      m_cnt <= m_clr ? 0 : (m_cnt + 1) % 1024;
      for (int t = 0; t < NT; t++) m_ph[t] <= {m_ph[t][2:0], ext[t]};
    end
  end

  function automatic bit exp_tick(int t);
    int s = int'(sel[t*3 +: 3]);
    int div;
    case (s)
      0: return 0;
      1: return !m_clr;
      2, 3, 4, 5: begin
        div = (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
        return !m_clr && (m_cnt % div) == div - 1;
      end
      6: return !m_ph[t][2] && m_ph[t][3];
      default: return m_ph[t][2] && !m_ph[t][3];
    endcase
  endfunction

  function automatic string sel_tag(int t);
    int s = int'(sel[t*3 +: 3]);
    if (s == 0 || s == 1) return (m_clr && s == 1) ? "R4" : "R6";
    if (s <= 5) return m_clr ? "R4" : "R7";
    if (s == 6) return "R9";
    return "R8";
  endfunction

  task automatic compare();
    logic [7:0] er = {m_hold, m_cap, 5'b0, m_clr};
    vectors++;
    if (rd !== er || cap !== m_cap) begin
      errors++;
      $display("FAIL %s/R2/R3 reg: got %02h cap %b exp %02h cap %b @%0t",
               phase, rd, cap, er, m_cap, $time);
    end
    for (int t = 0; t < NT; t++) begin
      bit e = exp_tick(t);
      vectors++;
      if (tick[t] !== e) begin
        errors++;
        $display("FAIL %s/%s tick[%0d] sel %0d: got %b exp %b @%0t",
                 phase, sel_tag(t), t, sel[t*3 +: 3], tick[t], e, $time);
      end
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) compare();
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); we = 1; wd = v;
    @(negedge clk); we = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int hold_a, hold_b;
    void'($urandom(32'h1a2b3c4d));
    // R1: state while in reset
    cyc(3);
    #1;
    vectors++;
    if (rd !== 8'h00 || cap !== 1'b0 || tick !== '0) begin
      errors++;
      $display("FAIL R1 reset: rd %02h cap %b tick %b exp 00 0 00", rd, cap, tick);
    end
    @(negedge clk); rst_n = 1;
    cyc(4);

    // R2: field placement with unused bits written as ones
    phase = "R2";
    wr(8'h7e); cyc(3);
    wr(8'h00); cyc(2);

    // R6 undivided on both timers, then R3 one-cycle clear
    phase = "R3";
    sel = {3'd1, 3'd1}; cyc(5);
    wr(8'h01); cyc(5);
    sel = {3'd2, 3'd0}; cyc(20);

    // R4 hold with tap selects, R5 aligned release
    phase = "R4";
    wr(8'h81);
    sel = {3'd1, 3'd3}; cyc(30);
    sel = {3'd5, 3'd2}; cyc(30);
    phase = "R5";
    wr(8'h00);
    cyc(1100);
    sel = {3'd4, 3'd3}; cyc(600);

    // R10 external edges get through while held; R8/R9 each polarity
    phase = "R10";
    wr(8'hc1);
    sel = {3'd6, 3'd7};
    for (int i = 0; i < 12; i++) begin
      ext[0] = ~ext[0];
      if (i % 3 == 0) ext[1] = ~ext[1];
      cyc(2 + (i % 4));
    end
    wr(8'h00);
    sel = {3'd7, 3'd6};
    for (int i = 0; i < 10; i++) begin
      ext = ext ^ 2'b11;
      cyc(3);
    end

    // R11 random mix: independent selects and pins
    phase = "R11";
    hold_a = 2; hold_b = 2;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      we = 0;
      if ($urandom_range(99) < 3) begin
        we = 1;
        wd = 8'($urandom);
        if ($urandom_range(3) != 0) wd[7] = 0;
      end
      if ($urandom_range(99) < 2) sel[2:0] = 3'($urandom);
      if ($urandom_range(99) < 2) sel[5:3] = 3'($urandom);
      if (--hold_a == 0) begin ext[0] = ~ext[0]; hold_a = $urandom_range(6, 2); end
      if (--hold_b == 0) begin ext[1] = ~ext[1]; hold_b = $urandom_range(9, 2); end
    end
    @(negedge clk); we = 0;
    cyc(4);
    done = 1;
    summary();
  end
endmodule